// File: doc/BRIEF.md
# Locked Fixed-Priority Bus Arbiter

This block decides which of several agents drives a shared memory bus. Every agent presents a request line, a lock line, an interrupt-acknowledge line and a done strobe that marks the end of each of its transactions. The arbiter answers with a one-hot grant vector and a bus-locked flag. Priority is fixed: agent 0 always wins over agent 1, and so on up to the last agent. No fairness is offered, so a busy high-priority agent can starve the others, and that is left to software.

A granted agent keeps the bus until its done strobe. If its lock line or its interrupt-acknowledge line is high in the cycle of that strobe, the grant stays with it for the next transaction, and this repeats for as many transactions as the agent needs. A multi-cycle operand therefore stays protected however many bus cycles it is split into. Once the owner finishes a transaction with both lines low, the arbiter picks the next owner from the requests present in that same cycle. Lock and interrupt-acknowledge lines from agents that do not hold the grant are ignored.

Top module: `arb_lock_bus`

## Requirements
- R1: After reset, the grant is all zero and bus_locked is low.
- R2: When no agent holds the grant, the grant in the next cycle goes to the lowest-numbered requesting agent (bit i of the grant is agent i; agent 0 has the highest priority). If nothing is requested, the grant stays all zero.
- R3: The grant is one-hot or all zero in every cycle.
- R4: The grant does not change until the current owner raises its done strobe. Done strobes from other agents have no effect.
- R5: If the owner raises done while its lock and iack lines are both low, the next grant goes to the lowest-numbered agent requesting in that cycle. If there are no requests, the next grant is all zero.
- R6: If the owner raises done while its lock line is high, it keeps the grant. This repeats for any number of back-to-back transactions.
- R7: If the owner drops its lock line partway through a transaction, it keeps the grant until that transaction's done strobe.
- R8: Lock and iack lines from agents that do not hold the grant change neither the grant nor bus_locked.
- R9: In every cycle, bus_locked is high exactly when some agent holds the grant and that agent's lock or iack line is high in that cycle.
- R10: An owner's iack line counts as a lock. Done raised with iack high keeps the grant.
- R11: While the bus is owned, a request from a higher-priority agent does not take the grant away before the owner's release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NUM_AGENTS | Bus request per agent |
| lock | input | NUM_AGENTS | Lock hold per agent |
| iack | input | NUM_AGENTS | Interrupt-acknowledge sequence in progress, per agent |
| done | input | NUM_AGENTS | Transaction-complete strobe per agent |
| grant | output | NUM_AGENTS | One-hot bus grant (or all zero) |
| bus_locked | output | 1 | The granted owner is holding the bus locked |

## Verification
The bench builds the arbiter with its default of four agents. With four agents, every priority position can be tried: the top agent, two middle agents and the bottom agent, each as owner and as challenger. The directed phases cover these cases:
- locked runs of several transactions;
- a lock dropped partway through a transaction;
- lock and iack raised by agents without the grant;
- an iack-held release.

A long stretch of random request, lock, iack and done patterns then drives handovers with many requests pending at once. A behavioural owner model is compared with the design on every cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
    // Why the next grant takes the value it does.
    typedef enum logic [1:0] {
        DEC_IDLE_PICK = 2'd0,
        DEC_HOLD      = 2'd1,
        DEC_REPICK    = 2'd2
    } arb_dec_e;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int NUM_AGENTS = 4
) (
    input  logic [NUM_AGENTS-1:0] req,
    output logic [NUM_AGENTS-1:0] pick
);
    // seen[i] is high when any agent below index i is requesting.
    logic [NUM_AGENTS:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_stage
        assign seen[i+1] = seen[i] | req[i];
        assign pick[i]   = req[i] & ~seen[i];
    end

    logic unused_top;
    assign unused_top = seen[NUM_AGENTS];
endmodule

// File: rtl/arb_lock_sense.sv
module arb_lock_sense #(
    parameter int NUM_AGENTS = 4
) (
    input  logic [NUM_AGENTS-1:0] grant,
    input  logic [NUM_AGENTS-1:0] lock,
    input  logic [NUM_AGENTS-1:0] iack,
    input  logic [NUM_AGENTS-1:0] done,
    output logic                  owned,
    output logic                  owner_held,
    output logic                  owner_done
);
    logic [NUM_AGENTS-1:0] held_vec;
    logic [NUM_AGENTS-1:0] own_held_vec;
    logic [NUM_AGENTS-1:0] own_done_vec;

    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_agent
        // An interrupt-acknowledge sequence is held exactly like a lock.
        assign held_vec[i]     = lock[i] | iack[i];
        assign own_held_vec[i] = grant[i] & held_vec[i];
        assign own_done_vec[i] = grant[i] & done[i];
    end

    assign owned      = |grant;
    assign owner_held = |own_held_vec;
    assign owner_done = |own_done_vec;
endmodule

// File: rtl/arb_lock_bus.sv
module arb_lock_bus
    import arb_pkg::*;
#(
    parameter int NUM_AGENTS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_AGENTS-1:0] req,
    input  logic [NUM_AGENTS-1:0] lock,
    input  logic [NUM_AGENTS-1:0] iack,
    input  logic [NUM_AGENTS-1:0] done,
    output logic [NUM_AGENTS-1:0] grant,
    output logic                  bus_locked
);
    typedef struct packed {
        logic [NUM_AGENTS-1:0] grant;
    } state_t;

    state_t   st_d, st_q;
    arb_dec_e dec;

    logic [NUM_AGENTS-1:0] winner;
    logic                  owned;
    logic                  owner_held;
    logic                  owner_done;

    arb_prio_pick #(.NUM_AGENTS(NUM_AGENTS)) u_pick (
        .req  (req),
        .pick (winner)
    );

    arb_lock_sense #(.NUM_AGENTS(NUM_AGENTS)) u_sense (
        .grant      (st_q.grant),
        .lock       (lock),
        .iack       (iack),
        .done       (done),
        .owned      (owned),
        .owner_held (owner_held),
        .owner_done (owner_done)
    );

    always_comb begin
        st_d = st_q;
        if (!owned) begin
            dec = DEC_IDLE_PICK;
        end else if (owner_done && !owner_held) begin
            dec = DEC_REPICK;
        end else begin
            dec = DEC_HOLD;
        end

        case (dec)
            DEC_IDLE_PICK: st_d.grant = winner;
            DEC_REPICK:    st_d.grant = winner;
            default:       st_d.grant = st_q.grant;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant      = st_q.grant;
    assign bus_locked = owner_held;
endmodule

// File: rtl/arb_lock_bus_chk.sv
module arb_lock_bus_chk #(
    parameter int NUM_AGENTS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_AGENTS-1:0] req,
    input logic [NUM_AGENTS-1:0] lock,
    input logic [NUM_AGENTS-1:0] iack,
    input logic [NUM_AGENTS-1:0] done,
    input logic [NUM_AGENTS-1:0] grant,
    input logic                  bus_locked
);
    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_hold_until_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && ((grant & done) == '0)) |=> (grant == $past(grant)));

    p_keep_when_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & done & (lock | iack)) != '0) |=> (grant == $past(grant)));

    p_idle_serves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant == '0) && (req != '0)) |=> (grant != '0));

    p_locked_needs_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_locked |-> (grant != '0));
endmodule

bind arb_lock_bus arb_lock_bus_chk #(.NUM_AGENTS(NUM_AGENTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .lock       (lock),
    .iack       (iack),
    .done       (done),
    .grant      (grant),
    .bus_locked (bus_locked)
);

// File: tb/tb_arb_lock_bus.sv
`timescale 1ns/1ps
module tb_arb_lock_bus;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0, lock = '0, iack = '0, done = '0;
    logic [N-1:0] grant;
    logic         bus_locked;

    int checks = 0;
    int failures = 0;
    int owner = -1;   // reference model: index of bus owner, -1 when free

    always #2 clk = ~clk;

    arb_lock_bus #(.NUM_AGENTS(N)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .lock(lock), .iack(iack),
        .done(done), .grant(grant), .bus_locked(bus_locked)
    );

    function automatic int lowest(input logic [N-1:0] r);
        for (int i = 0; i < N; i++) if (r[i]) return i;
        return -1;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of inputs, compare outputs against the model, then advance the model.
    task automatic step(input logic [N-1:0] r, input logic [N-1:0] l,
                        input logic [N-1:0] d, input logic [N-1:0] k,
                        input string tag);
        logic [N-1:0] exp_g;
        logic         exp_l;
        @(negedge clk);
        req = r; lock = l; done = d; iack = k;
        #0.5;
        exp_g = (owner < 0) ? '0 : (N'(1) << owner);
        exp_l = (owner >= 0) && (l[owner] || k[owner]);
        check(grant == exp_g, tag, "grant", int'(grant), int'(exp_g));
        check(bus_locked == exp_l, tag, "bus_locked", int'(bus_locked), int'(exp_l));
        check($onehot0(grant), "R3", "onehot", int'(grant), int'(exp_g));
        @(posedge clk);
        if (owner < 0 || (d[owner] && !(l[owner] || k[owner])))
            owner = lowest(r);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R1 reset");
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R2 idle none");
        // R2: agents 1 and 3 request, agent 1 wins
        step(4'b1010, 4'b0000, 4'b0000, 4'b0000, "R2 idle pick");
        step(4'b1010, 4'b0000, 4'b0000, 4'b0000, "R2 granted");
        // R4 / R11: others' done and higher-priority request do not move the grant
        step(4'b1011, 4'b0000, 4'b1001, 4'b0000, "R4 foreign done");
        step(4'b1011, 4'b0000, 4'b0000, 4'b0000, "R11 no preempt");
        // R5: owner finishes unlocked, agent 0 takes over
        step(4'b1001, 4'b0000, 4'b0010, 4'b0000, "R5 release");
        step(4'b1001, 4'b0001, 4'b0000, 4'b0000, "R9 locked");
        // R6: several locked transactions in a row
        for (int t = 0; t < 4; t++) begin
            step(4'b1110, 4'b0001, 4'b0001, 4'b0000, "R6 locked run");
            step(4'b1110, 4'b0001, 4'b0000, 4'b0000, "R6 between");
        end
        // R7: lock dropped mid-transaction, grant waits for done
        step(4'b1000, 4'b0000, 4'b0000, 4'b0000, "R7 mid release");
        step(4'b1000, 4'b0000, 4'b0000, 4'b0000, "R7 still held");
        step(4'b1000, 4'b0000, 4'b0001, 4'b0000, "R7 done");
        step(4'b1000, 4'b0000, 4'b0000, 4'b0000, "R5 agent3 owns");
        // R8: lock and iack from non-owners are ignored
        step(4'b0111, 4'b0111, 4'b0000, 4'b0110, "R8 foreign lock");
        step(4'b0111, 4'b0111, 4'b0111, 4'b0001, "R8 foreign done");
        // R10: iack held at done keeps the grant
        step(4'b0111, 4'b0000, 4'b1000, 4'b1000, "R10 iack hold");
        step(4'b0111, 4'b0000, 4'b0000, 4'b1000, "R10 iack kept");
        step(4'b0000, 4'b0000, 4'b1000, 4'b0000, "R5 release none");
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R5 idle after");
        // Random phase: every rule at once
        for (int t = 0; t < 3000; t++) begin
            step(N'($urandom), N'($urandom) & N'($urandom), N'($urandom),
                 N'($urandom) & N'($urandom) & N'($urandom), "R9 random");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule